// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs exactly one Clause 22 transaction for each software command. Software reaches it through a small memory-mapped register port of 32-bit words. It writes the outgoing value into the data word, then writes a command word that names the PHY, the register and the operation, with the busy bit set. While the frame runs the busy bit reads back as 1. At the end of the frame hardware clears busy. For a read, hardware also stores the 16 returned bits and a flag that says whether the PHY answered.

The block makes MDC from the system clock with a divider of `DIV_HALF` system cycles per MDC half period. It drives the MDIO pad through a separate output value and output enable, and reads the pad back through `mdio_i`. The MDIO value is updated only on the falling edge of MDC. Returned bits are sampled on the rising edge of MDC. While MDC is idle it stays low and the pad is not driven.

Register port: `bus_wr` writes `bus_wdata` to `bus_addr` at a rising clock edge. `bus_rdata` is a combinational read of the word that `bus_addr` selects. Offsets are byte addresses:
- command word at 0x3C0
- data word at 0x3C4
- status word at 0x3D0

Any other offset reads as zero.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the command, data and status words read as zero, `mdc` is low and `mdio_oe` is low.
- R2: A write to the command word starts a frame only when bit 20 (busy) is set and bit 17 (read) or bit 16 (write) is set. Read wins if both are set. Busy reads back as 1 from the cycle after that write and returns to 0 when the frame ends. The command word reads back busy at bit 20, read at bit 17, write at bit 16, the PHY address at bits 12:8 and the register number at bits 4:0.
- R3: A write frame carries, most significant bit first:
  - `PRE_LEN` ones (32 by default)
  - start bits 01 and opcode 01
  - the 5-bit PHY address and the 5-bit register number
  - turnaround 10
  - the 16-bit value from data word bits 15:0

  `mdio_oe` stays high for every bit. `mdio_o` and `mdio_oe` never change while `mdc` is high.
- R4: A read frame drives the preamble, start bits 01, opcode 10, the address and the register. It then releases MDIO (`mdio_oe` low) for the two turnaround bits and the 16 data bits.
- R5: Read data is sampled on MDC rising edges, MSB first, and stored in data word bits 31:16. Data word bits 15:0 are not changed by a read.
- R6: Status bit 0 is set when a read ends and the PHY did not drive the second turnaround bit low. It is cleared when a read ends with that bit low.
- R7: A command written while busy is 1 is ignored. The command word readback does not change, and the frame already running completes with its original fields. No second frame follows.
- R8: While a frame runs, MDC has a period of 2×`DIV_HALF` system clocks, and each frame has `PRE_LEN`+32 MDC periods. MDC is low when no frame runs.
- R9: A command write without bit 20, or without bit 17 and bit 16, is ignored. No frame starts and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad value as seen by the master |

## Verification
The bench builds the block with `DIV_HALF` = 3, which keeps a 64-bit frame near 400 system cycles. At that setting MDC has uneven counter phases, so a tick aligned to the wrong edge shows up in the measured period. `PRE_LEN` is left at 32, so the full frame layout is checked bit for bit. A PHY model in the bench answers reads or stays silent, which covers both settings of the invalid flag. It also lets the bench issue a command that arrives in the middle of a running frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [11:0] OFF_CMD  = 12'h3C0;
  localparam logic [11:0] OFF_DATA = 12'h3C4;
  localparam logic [11:0] OFF_STAT = 12'h3D0;
  localparam int BUSY_BIT = 20;
  localparam int RD_BIT   = 17;
  localparam int WR_BIT   = 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e    op;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          term;

  assign term      = run && (cnt == LAST_CNT);
  assign rise_tick = term && !mdc;
  assign fall_tick = term && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc); // R8
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        run,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        ta_ok
);
  localparam int FRAME_BITS = PRE_LEN + 32;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] TA_FIRST   = IW'(PRE_LEN + 14);
  localparam logic [IW-1:0] TA_SECOND  = IW'(PRE_LEN + 15);
  localparam logic [IW-1:0] DATA_FIRST = IW'(PRE_LEN + 16);
  localparam logic [IW-1:0] LAST_BIT   = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_sh;
  logic [IW-1:0]         bit_idx;
  logic                  is_read;
  logic                  req_read;

  assign req_read = (req.op == OP_READ);
  assign mdio_o   = tx_sh[FRAME_BITS-1];
  assign mdio_oe  = run && (!is_read || (bit_idx < TA_FIRST));
  assign done     = run && fall_tick && (bit_idx == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      tx_sh   <= '0;
      bit_idx <= '0;
      is_read <= 1'b0;
      rx_data <= '0;
      ta_ok   <= 1'b0;
    end else if (start && !run) begin
      run     <= 1'b1;
      bit_idx <= '0;
      is_read <= req_read;
      ta_ok   <= 1'b0;
      tx_sh   <= {{PRE_LEN{1'b1}}, 2'b01, req.op, req.phy, req.regn,
                  (req_read ? 2'b11 : 2'b10),
                  (req_read ? 16'hFFFF : req.wdata)};
    end else if (run) begin
      if (rise_tick && is_read) begin
        if (bit_idx == TA_SECOND)
          ta_ok <= !mdio_i;
        if (bit_idx >= DATA_FIRST)
          rx_data <= {rx_data[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (bit_idx == LAST_BIT) begin
          run <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_read && fall_tick && bit_idx == TA_FIRST - 1'b1) |=> !mdio_oe); // R4
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!run && !mdio_oe)); // R2
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done,
  input  logic [15:0]       rx_data,
  input  logic              ta_ok,
  output logic              start,
  output mdio_req_t         req
);
  logic        busy, cmd_rd, cmd_wr, invalid;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] wr_val, rd_val;
  logic        sel_cmd, sel_data, sel_stat;

  assign sel_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
  assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));

  assign start = bus_wr && sel_cmd && !busy && bus_wdata[BUSY_BIT] &&
                 (bus_wdata[RD_BIT] || bus_wdata[WR_BIT]);

  assign req.op    = bus_wdata[RD_BIT] ? OP_READ : OP_WRITE;
  assign req.phy   = bus_wdata[12:8];
  assign req.regn  = bus_wdata[4:0];
  assign req.wdata = wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cmd_rd  <= 1'b0;
      cmd_wr  <= 1'b0;
      cmd_phy <= '0;
      cmd_reg <= '0;
      wr_val  <= '0;
      rd_val  <= '0;
      invalid <= 1'b0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        cmd_rd  <= bus_wdata[RD_BIT];
        cmd_wr  <= !bus_wdata[RD_BIT];
        cmd_phy <= bus_wdata[12:8];
        cmd_reg <= bus_wdata[4:0];
      end else if (done) begin
        busy <= 1'b0;
        if (cmd_rd) begin
          rd_val  <= rx_data;
          invalid <= !ta_ok;
        end
      end
      if (bus_wr && sel_data)
        wr_val <= bus_wdata[15:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cmd) begin
      bus_rdata[BUSY_BIT] = busy;
      bus_rdata[RD_BIT]   = cmd_rd;
      bus_rdata[WR_BIT]   = cmd_wr;
      bus_rdata[12:8]     = cmd_phy;
      bus_rdata[4:0]      = cmd_reg;
    end else if (sel_data) begin
      bus_rdata = {rd_val, wr_val};
    end else if (sel_stat) begin
      bus_rdata[0] = invalid;
    end
  end

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
  AST_DONE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R2
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && bus_wr && sel_cmd) |=>
      (busy && $stable(cmd_phy) && $stable(cmd_reg) && $stable(cmd_rd))); // R7
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DIV_HALF = 10,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        start, run, done, ta_ok, rise_tick, fall_tick;
  logic [15:0] rx_data;
  mdio_req_t   req;

  mdio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .rx_data(rx_data), .ta_ok(ta_ok), .start(start), .req(req)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rx_data(rx_data), .ta_ok(ta_ok)
  );

  AST_HOLD_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3
endmodule

// File: tb/mdio_ctrl_test.sv
`timescale 1ns/1ps
module mdio_ctrl_test;
  localparam int DIV = 3;
  localparam int PER = 8;
  localparam logic [11:0] A_CMD = 12'h3C0, A_DATA = 12'h3C4, A_STAT = 12'h3D0;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, errors = 0;
  int rises = 0, frame_base = 0;
  logic [63:0] cap = '0, oe_cap = '0;
  time last_rise = 0, prev_rise = 0;
  logic phy_present = 1'b1;
  logic [15:0] phy_resp = '0;
  logic phy_drv = 1'b0, phy_val = 1'b1;

  always #(PER/2) clk = !clk;

  mdio_ctrl #(.ADDR_W(12), .DIV_HALF(DIV), .PRE_LEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  always @(posedge mdc) begin
    cap       = {cap[62:0], mdio_i};
    oe_cap    = {oe_cap[62:0], mdio_oe};
    rises     = rises + 1;
    prev_rise = last_rise;
    last_rise = $time;
  end

  always @(negedge mdc) begin
    int k;
    k = rises - frame_base;
    if (phy_present && k == 47) begin
      phy_drv = 1'b1; phy_val = 1'b0;
    end else if (phy_present && k >= 48 && k < 64) begin
      phy_drv = 1'b1; phy_val = phy_resp[63-k];
    end else begin
      phy_drv = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    bit idle = 1'b0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      rd(A_CMD, v);
      idle = !v[20];
    end
    chk(idle, req, {63'b0, !idle}, 64'd0);
  endtask

  function automatic logic [63:0] wframe(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] rframe(input logic [4:0] p, input logic [4:0] r, input logic [1:0] ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, ta, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CMD, v);  chk(v == 0, "R1 cmd", v, 0);
    rd(A_DATA, v); chk(v == 0, "R1 data", v, 0);
    rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
    chk(mdc == 1'b0, "R1 mdc", mdc, 0);
    chk(mdio_oe == 1'b0, "R1 oe", mdio_oe, 0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr(A_DATA, 32'h0000_A5C3);
    frame_base = rises;
    wr(A_CMD, 32'h0011_1106);
    rd(A_CMD, v); chk(v == 32'h0011_1106, "R2 busy set", v, 32'h0011_1106);
    wait_idle("R2 frame end");
    rd(A_CMD, v); chk(v == 32'h0001_1106, "R2 busy clear", v, 32'h0001_1106);
    chk(cap == wframe(5'h11, 5'h06, 16'hA5C3), "R3 write bits", cap, wframe(5'h11, 5'h06, 16'hA5C3));
    chk(oe_cap == '1, "R3 write oe", oe_cap, '1);
    chk(rises - frame_base == 64, "R8 frame length", rises - frame_base, 64);
    chk(last_rise - prev_rise == 2*DIV*PER, "R8 mdc period", last_rise - prev_rise, 2*DIV*PER);
    rd(A_DATA, v); chk(v == 32'h0000_A5C3, "R5 upper untouched by write", v, 32'h0000_A5C3);
  endtask

  task automatic t_read(input bit present, input logic [15:0] resp, input logic [4:0] p, input logic [4:0] r);
    logic [31:0] v;
    logic [63:0] e;
    phy_present = present; phy_resp = resp;
    frame_base = rises;
    wr(A_CMD, 32'h0012_0000 | {19'b0, p, 3'b0, r});
    wait_idle("R2 read end");
    e = present ? rframe(p, r, 2'b10, resp) : rframe(p, r, 2'b11, 16'hFFFF);
    chk(cap == e, "R4 read bits", cap, e);
    chk(oe_cap == {{46{1'b1}}, 18'b0}, "R4 release", oe_cap, {{46{1'b1}}, 18'b0});
    rd(A_STAT, v); chk(v == {31'b0, !present}, "R6 invalid flag", v, {31'b0, !present});
    if (present) begin
      rd(A_DATA, v);
      chk(v == {resp, 16'hA5C3}, "R5 read data", v, {resp, 16'hA5C3});
    end
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    phy_present = 1'b1;
    wr(A_DATA, 32'h0000_1234);
    frame_base = rises;
    wr(A_CMD, 32'h0011_0203);
    repeat (10) @(negedge clk);
    wr(A_CMD, 32'h0012_1E1D);
    rd(A_CMD, v); chk(v == 32'h0011_0203, "R7 readback kept", v, 32'h0011_0203);
    wait_idle("R7 end");
    chk(cap == wframe(5'h02, 5'h03, 16'h1234), "R7 original frame", cap, wframe(5'h02, 5'h03, 16'h1234));
    repeat (200) @(negedge clk);
    chk(rises - frame_base == 64, "R7 no second frame", rises - frame_base, 64);
    chk(mdc == 1'b0, "R8 idle mdc", mdc, 0);
  endtask

  task automatic t_malformed(input logic [31:0] cmd);
    logic [31:0] v;
    frame_base = rises;
    wr(A_CMD, cmd);
    rd(A_CMD, v); chk(v[20] == 1'b0, "R9 busy stays 0", v, 0);
    repeat (100) @(negedge clk);
    chk(rises == frame_base, "R9 no frame", rises - frame_base, 0);
  endtask

  initial begin
    #(200000 * PER);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read(1'b1, 16'h3C5A, 5'h05, 5'h1F);
    t_read(1'b0, 16'h0000, 5'h07, 5'h02);
    t_read(1'b1, 16'h8001, 5'h1F, 5'h00);
    t_busy_ignore();
    t_malformed(32'h0002_0105);
    t_malformed(32'h0010_0105);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule